// File: doc/BRIEF.md
# Trap Entry Sequencer

This block carries out a processor's exception entry once a trap or interrupt has been requested. It takes a trap number together with a flag that selects the emulator-style entry. It also takes the current program counter, status word, supervisor stack pointer and table base. It then pushes two context words onto the supervisor stack through a 32-bit memory port and reads the handler address from a vector table.

The vector table is 1 KiB long and grows downward from the top of the region that starts at the table base. Entry n lives at base + 1024 - 4*(n+1). The emulator-style variant ignores the requested number and uses entry 9. Instead of disabling interrupts, it raises the interrupt level mask to a fixed value.

When the read of the vector completes, the block shows the new PC, stack pointer and status word and pulses `done` for one cycle. The core loads these values on that pulse.

Top module: `trap_entry_seq`

## Requirements
- R1: A request seen while idle is accepted. The first memory access is a write (`mem_we`=1) of the full status word to address ssp-4.
- R2: The second memory access is a write of pc+2 to address ssp-8.
- R3: The third memory access is a read (`mem_we`=0) at tbr + 1024 - 4*(n+1). This sum uses 32-bit wraparound and n is the 8-bit trap number. The word read becomes `new_pc`.
- R4: `new_ssp` equals ssp-8, with 32-bit wraparound. In `new_ps`, the stack-select bit (bit 5) is 0.
- R5: For a normal request (`req_emu`=0), `new_ps` is the status word with bit 4 (interrupt enable) and bit 5 cleared. All other bits are unchanged.
- R6: For an emulator-style request (`req_emu`=1), n is forced to 9 and bits 20:16 of `new_ps` become 4. Bit 4 keeps its value and bit 5 is cleared.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_wdata` and `mem_we` stay stable. Each request performs exactly three accesses, in the order R1, R2, R3.
- R8: `done` is high for exactly one cycle after the vector read completes. It is never high at the same time as `mem_req`.
- R9: A request presented while a sequence is in progress is ignored and does not change that sequence's accesses or results.
- R10: A synchronous active-high `rst` returns the block to idle, with `done` and `mem_req` low, including in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Trap request strobe |
| req_num | input | 8 | Trap number |
| req_emu | input | 1 | Emulator-style entry select |
| cur_pc | input | 32 | PC of the trapping instruction |
| cur_ps | input | 32 | Current status word |
| cur_ssp | input | 32 | Current supervisor stack pointer |
| cur_tbr | input | 32 | Vector table base |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access complete |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Handler address |
| new_ssp | output | 32 | Updated stack pointer |
| new_ps | output | 32 | Updated status word |

## Verification
The assertions assume that the memory raises `mem_ready` only while `mem_req` is high. They also assume it holds `mem_ready` for a single cycle per access. The bench memory model follows this: it counts a programmable number of wait cycles from the start of each access, gives one ready pulse, and then drops ready before the next access begins. Stack pointers in the stimulus are word aligned. Only one vector starts each run, and a request that overlaps it arrives while the sequence is busy.

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int          NUM_W       = 8,
  parameter int          IE_BIT      = 4,
  parameter int          S_BIT       = 5,
  parameter int          ILM_LSB     = 16,
  parameter int          ILM_W       = 5,
  parameter int          EMU_NUM     = 9,
  parameter int          EMU_ILM     = 4,
  parameter logic [31:0] TABLE_BYTES = 32'd1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [NUM_W-1:0] req_num,
  input  logic             req_emu,
  input  logic [31:0]      cur_pc,
  input  logic [31:0]      cur_ps,
  input  logic [31:0]      cur_ssp,
  input  logic [31:0]      cur_tbr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ready,
  output logic             done,
  output logic [31:0]      new_pc,
  output logic [31:0]      new_ssp,
  output logic [31:0]      new_ps
);

  typedef enum logic [2:0] {S_IDLE, S_PS, S_RA, S_VEC, S_FIN} st_t;

  st_t              st;
  logic [31:0]      pc_q, ps_q, ssp_q, tbr_q, vec_q;
  logic [NUM_W-1:0] num_q;
  logic             emu_q;
  logic [31:0]      vec_addr;

  assign vec_addr = tbr_q + TABLE_BYTES - ((32'(num_q) + 32'd1) << 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      pc_q  <= '0;
      ps_q  <= '0;
      ssp_q <= '0;
      tbr_q <= '0;
      vec_q <= '0;
      num_q <= '0;
      emu_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          pc_q  <= cur_pc;
          ps_q  <= cur_ps;
          ssp_q <= cur_ssp;
          tbr_q <= cur_tbr;
          emu_q <= req_emu;
          num_q <= req_emu ? NUM_W'(EMU_NUM) : req_num;
          st    <= S_PS;
        end
        S_PS:  if (mem_ready) st <= S_RA;
        S_RA:  if (mem_ready) st <= S_VEC;
        S_VEC: if (mem_ready) begin
          vec_q <= mem_rdata;
          st    <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_PS) || (st == S_RA) || (st == S_VEC);
  assign mem_we    = (st == S_PS) || (st == S_RA);
  assign mem_addr  = (st == S_PS) ? ssp_q - 32'd4 :
                     (st == S_RA) ? ssp_q - 32'd8 : vec_addr;
  assign mem_wdata = (st == S_PS) ? ps_q : pc_q + 32'd2;
  assign done      = (st == S_FIN);
  assign new_pc    = vec_q;
  assign new_ssp   = ssp_q - 32'd8;

  always_comb begin
    new_ps = ps_q;
    new_ps[S_BIT] = 1'b0;
    if (emu_q) new_ps[ILM_LSB +: ILM_W] = ILM_W'(EMU_ILM);
    else       new_ps[IE_BIT] = 1'b0;
  end

endmodule

// File: rtl/trap_entry_seq_chk.sv
module trap_entry_seq_chk #(
  parameter int S_BIT = 5
) (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ready,
  input logic        done,
  input logic [31:0] new_ps
);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  // R4
  sbit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !new_ps[S_BIT]);

  // R3
  read_to_done_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_ready) |=> done);

endmodule

bind trap_entry_seq trap_entry_seq_chk #(.S_BIT(S_BIT)) u_chk (.*);

// File: tb/trap_entry_seq_tb.sv
module trap_entry_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_emu = 1'b0;
  logic [7:0]  req_num = '0;
  logic [31:0] cur_pc = '0, cur_ps = '0, cur_ssp = '0, cur_tbr = '0;
  logic mem_req, mem_we, mem_ready = 1'b0, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0, new_pc, new_ssp, new_ps;

  int checks = 0, errors = 0;
  int wait_c = 0, cnt = 0, lcnt = 0;
  logic [31:0] la [4];
  logic [31:0] ld [4];
  logic        lw [4];

  always #4 clk = ~clk;

  trap_entry_seq u_dut (.*);

  always @(negedge clk) begin
    if (mem_req && !mem_ready && cnt >= wait_c) begin
      mem_ready <= 1'b1;
      mem_rdata <= mem_addr ^ 32'h5A5A_A5A5;
    end else begin
      mem_ready <= 1'b0;
      if (mem_req && !mem_ready) cnt <= cnt + 1; else cnt <= 0;
    end
  end

  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (lcnt < 4) begin
        la[lcnt] = mem_addr; ld[lcnt] = mem_wdata; lw[lcnt] = mem_we;
      end
      lcnt = lcnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ps(input logic [31:0] ps, input logic emu);
    logic [31:0] p = ps;
    p[5] = 1'b0;
    if (emu) p[20:16] = 5'd4; else p[4] = 1'b0;
    return p;
  endfunction

  function automatic logic [31:0] exp_vec(input logic [31:0] tbr, input logic [7:0] n, input logic emu);
    logic [31:0] nn = emu ? 32'd9 : {24'd0, n};
    return tbr + 32'd1024 - ((nn + 32'd1) * 32'd4);
  endfunction

  task automatic start(input logic [7:0] n, input logic emu, input logic [31:0] pc,
                       input logic [31:0] ps, input logic [31:0] ssp, input logic [31:0] tbr,
                       input int w);
    @(negedge clk);
    wait_c = w; lcnt = 0;
    req_valid = 1'b1; req_num = n; req_emu = emu;
    cur_pc = pc; cur_ps = ps; cur_ssp = ssp; cur_tbr = tbr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_and_check(input logic [7:0] n, input logic emu, input logic [31:0] pc,
                                  input logic [31:0] ps, input logic [31:0] ssp, input logic [31:0] tbr);
    int k = 0;
    logic [31:0] va;
    while (!done && k < 200) begin @(negedge clk); k++; end
    chk("R8 done seen", {31'd0, done}, 32'd1);
    va = exp_vec(tbr, n, emu);
    chk("R7 access count", lcnt, 32'd3);
    chk("R1 push ps addr", la[0], ssp - 32'd4);
    chk("R1 push ps data", ld[0], ps);
    chk("R1 push ps we", {31'd0, lw[0]}, 32'd1);
    chk("R2 push ra addr", la[1], ssp - 32'd8);
    chk("R2 push ra data", ld[1], pc + 32'd2);
    chk("R3 vec addr", la[2], va);
    chk("R3 vec read", {31'd0, lw[2]}, 32'd0);
    chk("R3 new_pc", new_pc, va ^ 32'h5A5A_A5A5);
    chk("R4 new_ssp", new_ssp, ssp - 32'd8);
    chk(emu ? "R6 new_ps" : "R5 new_ps", new_ps, exp_ps(ps, emu));
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done}, 32'd0);
  endtask

  localparam int NV = 5;
  localparam logic [7:0]  V_NUM [NV] = '{8'd3, 8'd0, 8'd255, 8'd200, 8'd7};
  localparam logic        V_EMU [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] V_PC  [NV] = '{32'h0000_1000, 32'h0000_1234, 32'hFFFF_FFFE, 32'h0040_0100, 32'h0000_0200};
  localparam logic [31:0] V_PS  [NV] = '{32'hFFFF_FFFF, 32'h0000_0030, 32'h0012_0010, 32'hFFFF_FFFF, 32'h000F_0020};
  localparam logic [31:0] V_SSP [NV] = '{32'h0000_2000, 32'h0000_0100, 32'h0000_0008, 32'h0001_0000, 32'h0000_0004};
  localparam logic [31:0] V_TBR [NV] = '{32'h0000_8000, 32'h0000_4000, 32'h0001_0000, 32'h0000_C000, 32'hFFFF_FF00};
  localparam int          V_W   [NV] = '{0, 2, 1, 0, 3};

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset done", {31'd0, done}, 32'd0);
    chk("R10 reset mem_req", {31'd0, mem_req}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      start(V_NUM[i], V_EMU[i], V_PC[i], V_PS[i], V_SSP[i], V_TBR[i], V_W[i]);
      finish_and_check(V_NUM[i], V_EMU[i], V_PC[i], V_PS[i], V_SSP[i], V_TBR[i]);
    end

    // R9: a second request arrives while busy
    start(8'd1, 1'b0, 32'h0000_0500, 32'h0000_00F0, 32'h0000_3000, 32'h0000_2000, 3);
    req_valid = 1'b1; req_num = 8'd50; req_emu = 1'b1;
    cur_pc = 32'h1111_1110; cur_ps = '0; cur_ssp = 32'h9000; cur_tbr = 32'h7000;
    @(negedge clk); @(negedge clk);
    req_valid = 1'b0;
    finish_and_check(8'd1, 1'b0, 32'h0000_0500, 32'h0000_00F0, 32'h0000_3000, 32'h0000_2000);
    repeat (10) @(negedge clk);
    chk("R9 no extra access", lcnt, 32'd3);

    // R10: reset in the middle of a sequence
    start(8'd4, 1'b0, 32'h100, 32'h10, 32'h800, 32'h400, 4);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid reset mem_req", {31'd0, mem_req}, 32'd0);
    chk("R10 mid reset done", {31'd0, done}, 32'd0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 stays idle", {31'd0, mem_req | done}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule